// File: doc/BRIEF.md
# Dual Halfword Multiply-Accumulate Unit

This block is a pipelined signed multiplier for signal-processing datapaths. Its dual mode splits each 32-bit operand into two signed 16-bit halves. It multiplies the matching halves of A and B, with the halves of B optionally exchanged first. It then adds the two products together, or takes their difference, and can add an accumulator of either 32 or 64 bits to the outcome.

A second mode, the high-word mode, forms the full signed 64-bit product of two 32-bit operands. It adds only the upper 32 bits of that product to a 32-bit accumulator. The low half of the product is dropped without any rounding.

One operation is accepted per clock whenever `in_valid` is high. Its result appears, qualified by `out_valid`, exactly two clock edges later. Between valid results the result port keeps the last value it produced.

Top module: `dmac_unit`

## Requirements
- R1: In dual mode with `in_sub`=0 and `in_swap`=0, the combination is A[15:0]*B[15:0] + A[31:16]*B[31:16], with every half taken as a signed 16-bit two's complement number (0x00030002, 0x00050004, accumulator 0x20000000 gives 0x20000017; 0xFFFDFFFF with 0x00040002 and no accumulator gives -14).
- R2: With `in_swap`=1 in dual mode, the halves of B are exchanged before multiplying, so the products are A[15:0]*B[31:16] and A[31:16]*B[15:0] (0x00030002, 0x00050004, accumulator 0x800 gives 0x816).
- R3: With `in_sub`=1 in dual mode, the combination is the low-half product minus the high-half product, after any swap (0x00030006, 0x00050004, accumulator 0x800 gives 0x809; with swap, 0x00030002 and 0x00050004 give 0x7FE).
- R4: With `in_acc_en`=0 the accumulator is taken as zero whatever `acc_in` holds. With `in_acc_en`=1, `acc_in` is added.
- R5: In 32-bit accumulate modes (dual with `in_long`=0, and the high-word mode), the sum of `acc_in[31:0]` and the 32-bit term wraps modulo 2^32. `result[63:32]` repeats `result[31]`, and `acc_in[63:32]` has no effect.
- R6: In dual mode with `in_long`=1, the combination is sign-extended and added to the full 64-bit `acc_in` modulo 2^64 (accumulator 0x200000000 gives 0x200000017).
- R7: The dual combination is formed at 33 bits before accumulation. Two products of 0x8000*0x8000 therefore sum to +2^31, which gives 0x0000000080000000 in the 64-bit mode.
- R8: With `in_msw`=1, bits 63:32 of the signed 64-bit product of `op_a` and `op_b` are added to the accumulator by truncation, with no rounding. `in_sub`, `in_swap` and `in_long` have no effect in this mode (0x40000000*0x10 with accumulator 0x300 gives 0x304; -1*1 gives 0xFFFFFFFF_FFFFFFFF).
- R9: `out_valid` equals `in_valid` as sampled two rising edges earlier, with the matching result alongside. A new operation can be accepted on every cycle.
- R10: Synchronous active-high reset clears `out_valid` and `result` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| in_msw | input | 1 | 1 selects the high-word mode, 0 the dual mode |
| in_sub | input | 1 | Dual mode: subtract the high-half product |
| in_swap | input | 1 | Dual mode: exchange the halves of B |
| in_long | input | 1 | Dual mode: 64-bit accumulator |
| in_acc_en | input | 1 | Add the accumulator input |
| op_a | input | 32 | Operand A |
| op_b | input | 32 | Operand B |
| acc_in | input | 64 | Accumulator input |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Result, sign-extended in 32-bit modes |

## Verification
The bench uses the default halfword width of 16, which makes the accumulators 32 and 64 bits wide. At that width the fixed sample values can be checked bit for bit, and so can the boundaries that matter: 0x8000 times 0x8000 in both halves, the 2^32 wrap, and the negative high word that shows truncation. A behavioural model written with integer types covers directed cases and a few hundred random operations with gaps in `in_valid`. It exercises every combination of mode bits and the ignored controls in the high-word mode.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
    parameter int HW = 16;              // halfword width
    localparam int WW = 2 * HW;         // word width
    localparam int LW = 4 * HW;         // long accumulator width
    localparam int PW = 2 * HW;         // halfword product width
    localparam int CW = 2 * HW + 1;     // combined dual term width

    typedef enum logic {
        MODE_DUAL = 1'b0,
        MODE_MSW  = 1'b1
    } mode_e;

    typedef struct packed {
        mode_e mode;
        logic  sub;
        logic  lng;
    } ctl_t;

    typedef struct packed {
        logic                valid;
        ctl_t                ctl;
        logic [1:0][PW-1:0]  hp;     // halfword products, index 0 = low half
        logic [WW-1:0]       wp_hi;  // upper word of the full product
        logic [LW-1:0]       acc;    // accumulator, zero when disabled
    } s1_t;

    function automatic logic [LW-1:0] sext_word(input logic [WW-1:0] w);
        return {{(LW-WW){w[WW-1]}}, w};
    endfunction
endpackage

// File: rtl/dmac_mul_stage.sv
module dmac_mul_stage
    import dmac_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic                 in_msw,
    input  logic                 in_sub,
    input  logic                 in_swap,
    input  logic                 in_long,
    input  logic                 in_acc_en,
    input  logic [WW-1:0]        op_a,
    input  logic [WW-1:0]        op_b,
    input  logic [LW-1:0]        acc_in,
    output s1_t                  s1
);
    logic [1:0][PW-1:0]  hprod;
    logic signed [LW-1:0] wprod;
    logic [WW-1:0]        wp_hi;

    for (genvar i = 0; i < 2; i++) begin : g_half
        logic [HW-1:0] b_sel;
        assign b_sel    = in_swap ? op_b[(1-i)*HW +: HW] : op_b[i*HW +: HW];
        assign hprod[i] = $signed(op_a[i*HW +: HW]) * $signed(b_sel);
    end

    assign wprod = $signed(op_a) * $signed(op_b);
    assign wp_hi = WW'(wprod >>> WW);   // truncating high word

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
        end else begin
            s1.valid <= in_valid;
            if (in_valid) begin
                s1.ctl.mode <= in_msw ? MODE_MSW : MODE_DUAL;
                s1.ctl.sub  <= in_sub;
                s1.ctl.lng  <= in_long;
                s1.hp       <= hprod;
                s1.wp_hi    <= wp_hi;
                s1.acc      <= in_acc_en ? acc_in : '0;
            end
        end
    end

    // R9: first stage tracks the input qualifier one cycle later
    a_r9_stage_valid: assert property (@(posedge clk) disable iff (rst)
        s1.valid == $past(in_valid));
endmodule

// File: rtl/dmac_acc_stage.sv
module dmac_acc_stage
    import dmac_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  s1_t            s1,
    output logic           out_valid,
    output logic [LW-1:0]  result
);
    logic signed [CW-1:0] e_lo, e_hi, comb;
    logic [WW-1:0]        lo_sum;
    logic [LW-1:0]        nxt;

    assign e_lo = $signed(s1.hp[0]);
    assign e_hi = $signed(s1.hp[1]);
    assign comb = s1.ctl.sub ? (e_lo - e_hi) : (e_lo + e_hi);

    always_comb begin
        lo_sum = '0;
        nxt    = '0;
        if (s1.ctl.mode == MODE_MSW) begin
            lo_sum = s1.acc[WW-1:0] + s1.wp_hi;
            nxt    = sext_word(lo_sum);
        end else if (s1.ctl.lng) begin
            nxt = s1.acc + {{(LW-CW){comb[CW-1]}}, comb};
        end else begin
            lo_sum = s1.acc[WW-1:0] + comb[WW-1:0];
            nxt    = sext_word(lo_sum);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= s1.valid;
            if (s1.valid) result <= nxt;
        end
    end

    // R9: output qualifier follows the first stage by one cycle
    a_r9_out_follows: assert property (@(posedge clk) disable iff (rst)
        out_valid == $past(s1.valid));
    // R9: result only moves when a valid operation retires
    a_r9_result_hold: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(result));
endmodule

// File: rtl/dmac_unit.sv
module dmac_unit
    import dmac_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    input  logic           in_msw,
    input  logic           in_sub,
    input  logic           in_swap,
    input  logic           in_long,
    input  logic           in_acc_en,
    input  logic [31:0]    op_a,
    input  logic [31:0]    op_b,
    input  logic [63:0]    acc_in,
    output logic           out_valid,
    output logic [63:0]    result
);
    s1_t s1;

    dmac_mul_stage u_mul (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_msw(in_msw),
        .in_sub(in_sub), .in_swap(in_swap), .in_long(in_long),
        .in_acc_en(in_acc_en), .op_a(op_a), .op_b(op_b), .acc_in(acc_in),
        .s1(s1)
    );

    dmac_acc_stage u_acc (
        .clk(clk), .rst(rst), .s1(s1),
        .out_valid(out_valid), .result(result)
    );

    // R9: two-cycle latency end to end
    a_r9_latency: assert property (@(posedge clk) disable iff (rst)
        out_valid == $past(in_valid, 2));
    // R5: 32-bit modes deliver a sign-extended word
    a_r5_upper_sign: assert property (@(posedge clk) disable iff (rst)
        (out_valid && ($past(in_msw, 2) || !$past(in_long, 2)))
        |-> result[63:32] == {32{result[31]}});
    // R4: zero operand with accumulator disabled yields zero in every mode
    a_r4_zero_result: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(op_a, 2) == '0 && !$past(in_acc_en, 2))
        |-> result == '0);
    // R6: zero operand in the 64-bit dual mode passes the accumulator through
    a_r6_acc_pass: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(op_a, 2) == '0 && $past(in_acc_en, 2)
         && !$past(in_msw, 2) && $past(in_long, 2))
        |-> result == $past(acc_in, 2));
endmodule

// File: tb/dmac_unit_tb.sv
`timescale 1ns/1ps
module dmac_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0, in_msw = 1'b0, in_sub = 1'b0, in_swap = 1'b0;
    logic        in_long = 1'b0, in_acc_en = 1'b0;
    logic [31:0] op_a = '0, op_b = '0;
    logic [63:0] acc_in = '0;
    logic        out_valid;
    logic [63:0] result;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        bit          v;
        logic [63:0] e;
        string       tag;
    } exp_t;
    exp_t q[$];

    always #4 clk = ~clk;   // 125 MHz

    dmac_unit u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_msw(in_msw),
        .in_sub(in_sub), .in_swap(in_swap), .in_long(in_long),
        .in_acc_en(in_acc_en), .op_a(op_a), .op_b(op_b), .acc_in(acc_in),
        .out_valid(out_valid), .result(result)
    );

    function automatic logic [63:0] model(bit msw, bit sub, bit swp, bit lng,
                                          bit aen, logic [31:0] a,
                                          logic [31:0] b, logic [63:0] acc);
        longint p, c, r;
        int     w, hi;
        shortint al, ah, bl, bh;
        if (msw) begin
            p  = longint'($signed(a)) * longint'($signed(b));
            hi = int'(p >>> 32);
            w  = (aen ? int'(acc[31:0]) : 0) + hi;
            return 64'(longint'(w));
        end
        al = shortint'(a[15:0]);
        ah = shortint'(a[31:16]);
        bl = swp ? shortint'(b[31:16]) : shortint'(b[15:0]);
        bh = swp ? shortint'(b[15:0])  : shortint'(b[31:16]);
        c  = longint'(al) * longint'(bl);
        if (sub) c = c - longint'(ah) * longint'(bh);
        else     c = c + longint'(ah) * longint'(bh);
        if (lng) begin
            r = (aen ? longint'(acc) : 64'sd0) + c;
            return 64'(r);
        end
        w = (aen ? int'(acc[31:0]) : 0) + int'(c);
        return 64'(longint'(w));
    endfunction

    task automatic check_due();
        exp_t e;
        if (q.size() >= 2) begin
            e = q.pop_front();
            checks++;
            if (out_valid !== e.v) begin
                errors++;
                $display("FAIL %s/R9 out_valid got %0b exp %0b", e.tag, out_valid, e.v);
            end
            if (e.v) begin
                checks++;
                if (result !== e.e) begin
                    errors++;
                    $display("FAIL %s result got %h exp %h", e.tag, result, e.e);
                end
            end
        end
    endtask

    task automatic issue(bit v, bit msw, bit sub, bit swp, bit lng, bit aen,
                         logic [31:0] a, logic [31:0] b, logic [63:0] acc,
                         bit given, logic [63:0] exp_val, string tag);
        exp_t e;
        @(negedge clk);
        check_due();
        in_valid = v; in_msw = msw; in_sub = sub; in_swap = swp;
        in_long = lng; in_acc_en = aen; op_a = a; op_b = b; acc_in = acc;
        e.v   = v;
        e.e   = given ? exp_val : model(msw, sub, swp, lng, aen, a, b, acc);
        e.tag = tag;
        q.push_back(e);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        checks++;
        if (out_valid !== 1'b0 || result !== 64'h0) begin
            errors++;
            $display("FAIL R10 reset got v=%0b r=%h exp v=0 r=0", out_valid, result);
        end
        rst = 1'b0;

        // R1: plain dual add with accumulator
        issue(1,0,0,0,0,1, 32'h00030002, 32'h00050004, 64'h20000000, 1, 64'h20000017, "R1");
        // R2: exchange
        issue(1,0,0,1,0,1, 32'h00030002, 32'h00050004, 64'h800, 1, 64'h816, "R2");
        // R3: subtract, then subtract with exchange
        issue(1,0,1,0,0,1, 32'h00030006, 32'h00050004, 64'h800, 1, 64'h809, "R3");
        issue(1,0,1,1,0,1, 32'h00030002, 32'h00050004, 64'h800, 1, 64'h7FE, "R3");
        // R1 / R3: signed halves, no accumulator
        issue(1,0,0,0,0,0, 32'hFFFDFFFF, 32'h00040002, 64'h0, 1, 64'hFFFFFFFF_FFFFFFF2, "R1");
        issue(1,0,1,0,0,0, 32'hFFFDFFFF, 32'h00040002, 64'h0, 1, 64'h0000000A, "R3");
        // R4: accumulator ignored when disabled
        issue(1,0,0,0,0,0, 32'h00030002, 32'h00050004, 64'h12345678_9ABCDEF0, 1, 64'h17, "R4");
        // R6: 64-bit accumulate
        issue(1,0,0,0,1,1, 32'h00030002, 32'h00050004, 64'h2_00000000, 1, 64'h2_00000017, "R6");
        // R7: 33-bit combination
        issue(1,0,0,0,1,0, 32'h80008000, 32'h80008000, 64'h0, 1, 64'h00000000_80000000, "R7");
        issue(1,0,0,0,0,0, 32'h80008000, 32'h80008000, 64'h0, 1, 64'hFFFFFFFF_80000000, "R7");
        // R5: 32-bit wrap, upper accumulator bits have no effect
        issue(1,0,0,0,0,1, 32'h00000001, 32'h00000001, 64'hDEADBEEF_7FFFFFFF, 1, 64'hFFFFFFFF_80000000, "R5");
        // R8: high-word mode, truncation, ignored controls
        issue(1,1,0,0,0,1, 32'h40000000, 32'h00000010, 64'h300, 1, 64'h304, "R8");
        issue(1,1,1,1,1,1, 32'h00000200, 32'h00000004, 64'hFFFF0000_00000100, 1, 64'h100, "R8");
        issue(1,1,1,1,1,0, 32'hFFFFFFFF, 32'h00000001, 64'h5, 1, 64'hFFFFFFFF_FFFFFFFF, "R8");
        // R9: gap then random stream
        issue(0,0,0,0,0,0, 32'h0, 32'h0, 64'h0, 1, 64'h0, "R9");
        for (int i = 0; i < 400; i++) begin
            logic [3:0] sel;
            sel = 4'($urandom);
            issue(($urandom % 4) != 0, sel[0], sel[1], sel[2], sel[3], 1'($urandom),
                  (i % 7 == 0) ? 32'h0 : $urandom, $urandom,
                  {$urandom, $urandom}, 0, 64'h0, "R9");
        end
        repeat (3) issue(0,0,0,0,0,0, 32'h0, 32'h0, 64'h0, 1, 64'h0, "R9");
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule